// File: doc/BRIEF.md
# Interrupt Pin Qualifier

This block watches four active-low external interrupt pins and turns each valid event into a one-cycle pending pulse. A valid event is a run of deasserted (high) samples followed by a run of asserted (low) samples. Each run has a minimum length. In synchronous mode, pin levels are used as they arrive and each run needs one bus cycle. In asynchronous mode, every pin first passes through a two-flop synchronizer and each run needs two bus cycles. After a pulse, a pin must go high again before it can raise another event.

Static configuration inputs give three of the pins other roles:
- Pin 0 can report a message request instead of an interrupt.
- Pin 2 can carry the request line of an external interrupt controller.
- Pin 3 can become an open-drain acknowledge output. In that role the block latches its value, holds it through idle data cycles of the acknowledge transaction, and the pin's input detector is ignored.

A low level on pin 0 during reset is reserved. The block records it in a flag.

Top module: `irq_pin_qualifier`

## Requirements
- R1: With `async_mode`=0, a pin sampled high on at least one clock edge and then low on the next edge gives a pulse. The pulse is on `int_pend_o[i]`, where bit i belongs to pin i. It is visible right after the edge that sampled the first low level.
- R2: With `async_mode`=1, the pin passes through two flops. It needs at least two high samples and then two low samples. The pulse follows the fourth clock edge after the pin first goes low. Runs of one high or one low cycle give no pulse.
- R3: A pending pulse lasts exactly one cycle. A pin held low produces only one pulse. A new pulse needs a new high run.
- R4: With `cfg_pin0_msg`=1, pin 0 events appear on `msg_pend_o` and not on `int_pend_o[0]`. With 0, the reverse holds.
- R5: With `cfg_pin2_req`=1, pin 2 events appear on `ctl_req_o` and not on `int_pend_o[2]`. With 0, the reverse holds.
- R6: With `cfg_pin3_ack`=1, activity on pin 3 never raises `int_pend_o[3]`. With 0, pin 3 behaves like pin 1.
- R7: With `cfg_pin3_ack`=1, `ack_drive_o` takes `ack_req_i` one edge later while `bus_idle_i`=0. It holds its value on edges where `bus_idle_i`=1. With `cfg_pin3_ack`=0 it stays 0. A value of 1 means pull pin 3 low; the output never drives high.
- R8: `pin0_rsv_o` equals 1 when pin 0 was low on the last clock edge of reset, and 0 when it was high. It keeps that value until the next reset.
- R9: A pin held low through reset and after it gives no pulse until it has been high for the minimum run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| async_mode | input | 1 | 1 = pins asynchronous to the clock |
| cfg_pin0_msg | input | 1 | Pin 0 reports message requests |
| cfg_pin2_req | input | 1 | Pin 2 is the controller request line |
| cfg_pin3_ack | input | 1 | Pin 3 is the acknowledge output |
| pin_n_i | input | 4 | Active-low pin levels |
| ack_req_i | input | 1 | Acknowledge value from the bus sequencer |
| bus_idle_i | input | 1 | Idle data cycle: hold acknowledge |
| int_pend_o | output | 4 | Interrupt pending pulses, one per pin |
| msg_pend_o | output | 1 | Message request pulse from pin 0 |
| ctl_req_o | output | 1 | Controller request pulse from pin 2 |
| ack_drive_o | output | 1 | Pull pin 3 low |
| pin0_rsv_o | output | 1 | Pin 0 was low during reset |

## Verification
The detector is driven in both modes with four kinds of input:
- A minimal valid event (high, then low).
- Runs one cycle too short for the asynchronous minimum.
- A long low hold.
- A pin that is already low when reset ends.

Timed single-event checks give the exact latency of the direct path and of the synchronized path. The short runs show the two minimum lengths apart. The long hold shows a single pulse against retriggering. Each role bit is toggled with the same event applied, which shows whether the pulse is routed to the right output or suppressed.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;
    localparam int NPIN    = 4;
    localparam int PIN_MSG = 0;
    localparam int PIN_REQ = 2;
    localparam int PIN_ACK = 3;

    typedef enum logic {
        TIMING_SYNC  = 1'b0,
        TIMING_ASYNC = 1'b1
    } timing_e;
endpackage

// File: rtl/irq_run_detector.sv
module irq_run_detector #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             smp,
    input  logic [CNT_W-1:0] min_hi,
    input  logic [CNT_W-1:0] min_lo,
    output logic             fire
);
    typedef struct packed {
        logic             lvl;
        logic             qual;
        logic [CNT_W-1:0] run;
    } det_t;

    det_t q, d;
    logic [CNT_W-1:0] run_inc;

    always_comb begin
        d       = q;
        fire    = 1'b0;
        run_inc = (&q.run) ? q.run : q.run + 1'b1;
        if (!en) begin
            d = '0;
        end else if (smp != q.lvl) begin
            d.lvl  = smp;
            d.run  = {{(CNT_W-1){1'b0}}, 1'b1};
            d.qual = smp ? 1'b0 : (q.run >= min_hi);
            fire   = !smp && d.qual && (d.run == min_lo);
        end else begin
            d.run = run_inc;
            fire  = !smp && q.qual && (run_inc == min_lo) && (q.run != min_lo);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/irq_pin_qualifier.sv
module irq_pin_qualifier
    import irq_qual_pkg::*;
#(
    parameter int SYNC_MIN  = 1,
    parameter int ASYNC_MIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            async_mode,
    input  logic            cfg_pin0_msg,
    input  logic            cfg_pin2_req,
    input  logic            cfg_pin3_ack,
    input  logic [NPIN-1:0] pin_n_i,
    input  logic            ack_req_i,
    input  logic            bus_idle_i,
    output logic [NPIN-1:0] int_pend_o,
    output logic            msg_pend_o,
    output logic            ctl_req_o,
    output logic            ack_drive_o,
    output logic            pin0_rsv_o
);
    localparam int MAXMIN = (ASYNC_MIN > SYNC_MIN) ? ASYNC_MIN : SYNC_MIN;
    localparam int CNT_W  = $clog2(MAXMIN + 1) + 1;

    typedef struct packed {
        logic [NPIN-1:0] s0;
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] intp;
        logic            msg;
        logic            req;
        logic            ack;
        logic            rsv;
    } top_t;

    top_t q, d;
    timing_e          tmode;
    logic [NPIN-1:0]  smp, fire, en;
    logic [CNT_W-1:0] min_run;

    assign tmode   = timing_e'(async_mode);
    assign min_run = (tmode == TIMING_ASYNC) ? CNT_W'(ASYNC_MIN) : CNT_W'(SYNC_MIN);
    assign smp     = (tmode == TIMING_ASYNC) ? q.s1 : pin_n_i;

    for (genvar i = 0; i < NPIN; i++) begin : g_det
        assign en[i] = (i == PIN_ACK) ? !cfg_pin3_ack : 1'b1;
        irq_run_detector #(.CNT_W(CNT_W)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en[i]),
            .smp    (smp[i]),
            .min_hi (min_run),
            .min_lo (min_run),
            .fire   (fire[i])
        );
    end

    always_comb begin
        d      = q;
        d.s0   = pin_n_i;
        d.s1   = q.s0;
        d.intp = fire;
        d.msg  = fire[PIN_MSG] && cfg_pin0_msg;
        d.req  = fire[PIN_REQ] && cfg_pin2_req;
        if (cfg_pin0_msg) d.intp[PIN_MSG] = 1'b0;
        if (cfg_pin2_req) d.intp[PIN_REQ] = 1'b0;
        if (!cfg_pin3_ack)    d.ack = 1'b0;
        else if (!bus_idle_i) d.ack = ack_req_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.rsv <= !pin_n_i[PIN_MSG];
        end else begin
            q <= d;
        end
    end

    assign int_pend_o  = q.intp;
    assign msg_pend_o  = q.msg;
    assign ctl_req_o   = q.req;
    assign ack_drive_o = q.ack && cfg_pin3_ack;
    assign pin0_rsv_o  = q.rsv;
endmodule

// File: rtl/irq_pin_qualifier_chk.sv
module irq_pin_qualifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       async_mode,
    input logic       cfg_pin0_msg,
    input logic       cfg_pin2_req,
    input logic       cfg_pin3_ack,
    input logic [3:0] pin_n_i,
    input logic       bus_idle_i,
    input logic [3:0] int_pend_o,
    input logic       msg_pend_o,
    input logic       ctl_req_o,
    input logic       ack_drive_o,
    input logic       pin0_rsv_o
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pend_o != 4'b0) |=> ((int_pend_o & $past(int_pend_o)) == 4'b0)); // R3

    AST_SYNC_EDGE_PIN1: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pend_o[1] && !$past(async_mode) && !$past(async_mode, 2))
        |-> (!$past(pin_n_i[1]) && $past(pin_n_i[1], 2))); // R1

    AST_MSG_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pend_o |-> $past(cfg_pin0_msg)); // R4

    AST_INT0_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        int_pend_o[0] |-> !$past(cfg_pin0_msg)); // R4

    AST_REQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_req_o |-> $past(cfg_pin2_req)); // R5

    AST_INT2_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        int_pend_o[2] |-> !$past(cfg_pin2_req)); // R5

    AST_ACK_PIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        int_pend_o[3] |-> !$past(cfg_pin3_ack)); // R6

    AST_ACK_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_idle_i) && cfg_pin3_ack && $past(cfg_pin3_ack) && $past(cfg_pin3_ack, 2))
        |-> $stable(ack_drive_o)); // R7

    AST_ACK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pin3_ack |-> !ack_drive_o); // R7

    AST_RSV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(pin0_rsv_o)); // R8
endmodule

bind irq_pin_qualifier irq_pin_qualifier_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .async_mode   (async_mode),
    .cfg_pin0_msg (cfg_pin0_msg),
    .cfg_pin2_req (cfg_pin2_req),
    .cfg_pin3_ack (cfg_pin3_ack),
    .pin_n_i      (pin_n_i),
    .bus_idle_i   (bus_idle_i),
    .int_pend_o   (int_pend_o),
    .msg_pend_o   (msg_pend_o),
    .ctl_req_o    (ctl_req_o),
    .ack_drive_o  (ack_drive_o),
    .pin0_rsv_o   (pin0_rsv_o)
);

// File: tb/irq_pin_qualifier_bench.sv
module irq_pin_qualifier_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       async_mode = 1'b0;
    logic       cfg_pin0_msg = 1'b0;
    logic       cfg_pin2_req = 1'b0;
    logic       cfg_pin3_ack = 1'b0;
    logic [3:0] pin_n_i = 4'hF;
    logic       ack_req_i = 1'b0;
    logic       bus_idle_i = 1'b0;
    logic [3:0] int_pend_o;
    logic       msg_pend_o, ctl_req_o, ack_drive_o, pin0_rsv_o;

    int n_chk = 0;
    int n_fail = 0;
    int cnt_int [4] = '{0, 0, 0, 0};
    int cnt_msg = 0;
    int cnt_req = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_pin_qualifier u_irq_pin_qualifier (
        .clk(clk), .rst_n(rst_n), .async_mode(async_mode),
        .cfg_pin0_msg(cfg_pin0_msg), .cfg_pin2_req(cfg_pin2_req),
        .cfg_pin3_ack(cfg_pin3_ack), .pin_n_i(pin_n_i),
        .ack_req_i(ack_req_i), .bus_idle_i(bus_idle_i),
        .int_pend_o(int_pend_o), .msg_pend_o(msg_pend_o),
        .ctl_req_o(ctl_req_o), .ack_drive_o(ack_drive_o),
        .pin0_rsv_o(pin0_rsv_o)
    );

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            for (int i = 0; i < 4; i++) cnt_int[i] += int'(int_pend_o[i]);
            cnt_msg += int'(msg_pend_o);
            cnt_req += int'(ctl_req_o);
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_reset(input logic p0);
        @(negedge clk);
        rst_n = 1'b0;
        pin_n_i[0] = p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic evt(input int idx, input int h, input int l);
        pin_n_i[idx] = 1'b1;
        repeat (h) @(negedge clk);
        pin_n_i[idx] = 1'b0;
        repeat (l) @(negedge clk);
        pin_n_i[idx] = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset_state;
        do_reset(1'b1);
        chk(int_pend_o == 4'b0 && !msg_pend_o && !ctl_req_o && !ack_drive_o, "R1 reset outputs",
            int'({int_pend_o, msg_pend_o, ctl_req_o, ack_drive_o}), 0);
        chk(pin0_rsv_o == 1'b0, "R8 pin0 high in reset", int'(pin0_rsv_o), 0);
        do_reset(1'b0);
        chk(pin0_rsv_o == 1'b1, "R8 pin0 low in reset", int'(pin0_rsv_o), 1);
        pin_n_i[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk(pin0_rsv_o == 1'b1, "R8 flag held", int'(pin0_rsv_o), 1);
        do_reset(1'b1);
        chk(pin0_rsv_o == 1'b0, "R8 flag cleared", int'(pin0_rsv_o), 0);
    endtask

    task automatic t_sync_latency;
        repeat (2) @(negedge clk);
        pin_n_i[1] = 1'b0;
        @(negedge clk);
        chk(int_pend_o[1] == 1'b1, "R1 pulse after first low edge", int'(int_pend_o[1]), 1);
        @(negedge clk);
        chk(int_pend_o[1] == 1'b0, "R3 pulse one cycle", int'(int_pend_o[1]), 0);
        pin_n_i[1] = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_hold_low;
        int c0;
        c0 = cnt_int[1];
        evt(1, 1, 10);
        chk(cnt_int[1] == c0 + 1, "R3 long low one pulse", cnt_int[1] - c0, 1);
        evt(1, 1, 1);
        chk(cnt_int[1] == c0 + 2, "R3 re-arm after high", cnt_int[1] - c0, 2);
    endtask

    task automatic t_low_through_reset;
        int c0;
        pin_n_i[1] = 1'b0;
        do_reset(1'b1);
        c0 = cnt_int[1];
        repeat (6) @(negedge clk);
        chk(cnt_int[1] == c0, "R9 low after reset silent", cnt_int[1] - c0, 0);
        evt(1, 1, 1);
        chk(cnt_int[1] == c0 + 1, "R9 first valid event", cnt_int[1] - c0, 1);
    endtask

    task automatic t_async;
        int c0;
        async_mode = 1'b1;
        repeat (6) @(negedge clk);
        c0 = cnt_int[1];
        evt(1, 1, 1);
        evt(1, 1, 1);
        chk(cnt_int[1] == c0, "R2 one-cycle runs ignored", cnt_int[1] - c0, 0);
        pin_n_i[1] = 1'b0;
        @(negedge clk);
        pin_n_i[1] = 1'b1;
        @(negedge clk);
        pin_n_i[1] = 1'b0;
        repeat (6) @(negedge clk);
        chk(cnt_int[1] == c0, "R2 one-cycle high run ignored", cnt_int[1] - c0, 0);
        pin_n_i[1] = 1'b1;
        repeat (4) @(negedge clk);
        pin_n_i[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk(int_pend_o[1] == 1'b0, "R2 no pulse before fourth edge", int'(int_pend_o[1]), 0);
        @(negedge clk);
        chk(int_pend_o[1] == 1'b1, "R2 pulse at fourth edge", int'(int_pend_o[1]), 1);
        pin_n_i[1] = 1'b1;
        repeat (6) @(negedge clk);
        evt(1, 2, 2);
        chk(cnt_int[1] == c0 + 2, "R2 minimal async event", cnt_int[1] - c0, 2);
        async_mode = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_pin0_role;
        int m0, i0;
        cfg_pin0_msg = 1'b1;
        m0 = cnt_msg; i0 = cnt_int[0];
        evt(0, 1, 1);
        chk(cnt_msg == m0 + 1 && cnt_int[0] == i0, "R4 message mode",
            cnt_msg - m0 + 10 * (cnt_int[0] - i0), 1);
        cfg_pin0_msg = 1'b0;
        evt(0, 1, 1);
        chk(cnt_msg == m0 + 1 && cnt_int[0] == i0 + 1, "R4 interrupt mode",
            cnt_msg - m0 + 10 * (cnt_int[0] - i0), 11);
    endtask

    task automatic t_pin2_role;
        int r0, i0;
        cfg_pin2_req = 1'b1;
        r0 = cnt_req; i0 = cnt_int[2];
        evt(2, 1, 1);
        chk(cnt_req == r0 + 1 && cnt_int[2] == i0, "R5 request mode",
            cnt_req - r0 + 10 * (cnt_int[2] - i0), 1);
        cfg_pin2_req = 1'b0;
        evt(2, 1, 1);
        chk(cnt_req == r0 + 1 && cnt_int[2] == i0 + 1, "R5 interrupt mode",
            cnt_req - r0 + 10 * (cnt_int[2] - i0), 11);
    endtask

    task automatic t_pin3_role;
        int i0;
        cfg_pin3_ack = 1'b1;
        i0 = cnt_int[3];
        evt(3, 1, 1);
        evt(3, 2, 4);
        chk(cnt_int[3] == i0, "R6 pin3 input ignored", cnt_int[3] - i0, 0);
        cfg_pin3_ack = 1'b0;
        @(negedge clk);
        evt(3, 1, 1);
        chk(cnt_int[3] == i0 + 1, "R6 pin3 interrupt mode", cnt_int[3] - i0, 1);
    endtask

    task automatic t_ack;
        cfg_pin3_ack = 1'b1;
        bus_idle_i = 1'b0;
        ack_req_i = 1'b1;
        @(negedge clk);
        chk(ack_drive_o == 1'b1, "R7 ack follows request", int'(ack_drive_o), 1);
        bus_idle_i = 1'b1;
        ack_req_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(ack_drive_o == 1'b1, "R7 ack held in idle", int'(ack_drive_o), 1);
        bus_idle_i = 1'b0;
        @(negedge clk);
        chk(ack_drive_o == 1'b0, "R7 ack released", int'(ack_drive_o), 0);
        cfg_pin3_ack = 1'b0;
        ack_req_i = 1'b1;
        repeat (2) @(negedge clk);
        chk(ack_drive_o == 1'b0, "R7 ack off when pin is input", int'(ack_drive_o), 0);
        ack_req_i = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset_state();
        t_sync_latency();
        t_hold_low();
        t_low_through_reset();
        t_async();
        t_pin0_role();
        t_pin2_role();
        t_pin3_role();
        t_ack();
        repeat (3) @(negedge clk);
        report();
    end
endmodule